// File: doc/BRIEF.md
# SPI Register Write Sequencer

This block is a bit-banged SPI master that programs one register of an attached serial device for each request. A single start strobe captures an 8-bit register address and an 8-bit data value. The block then runs two transactions on its own. The first is a one-byte write-enable command followed by a close. The second is a three-byte frame (operation byte, address byte, data byte) followed by a close. The serial clock, chip select and data lines are produced as a series of fixed-length steps. Each step is held for a parameterised number of system clocks, which sets the serial rate.

A one-cycle done pulse marks the end of the request. When a request has finished, the lines rest with the clock high and chip select low until the next start. The device is never read back.

Top module: `spi_regwr_seq`

## Requirements
- R1: A start strobe seen while the block is idle captures `reg_addr` and `reg_data`. A start strobe seen while a request is in progress is ignored and does not change the bytes sent.
- R2: Every request sends two transactions. The first carries the 8-bit write-enable code (default 0x06). The second carries 24 bits: the write operation code (default 0x02) in bits 23:16, the address in bits 15:8 and the data in bits 7:0. All bits go out most significant bit first.
- R3: Every transaction opens with one step where chip select, clock and data are all low. The next step has chip select high, with clock and data still low.
- R4: Each bit takes two steps. In the first, chip select is high, the clock is low and data carries the bit. In the second, the clock goes high while chip select and data are held.
- R5: The last bit of a transaction is followed by one step with all lines low, then one step with only the clock high. A second identical close pair (all lines low, then only the clock high) follows before the next transaction or the end of the request.
- R6: Every step holds its line levels for exactly `STEP_CLKS` system clocks.
- R7: After reset, all lines are low and `done` is low. `done` is high for exactly one cycle, in the cycle after the final step of a request. From that cycle on, the lines rest at clock high, chip select low and data low until the next start.
- R8: A start strobe presented during the done cycle is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled only while idle |
| reg_addr | input | 8 | Target register address |
| reg_data | input | 8 | Value to write |
| spi_cs | output | 1 | Chip select, active high |
| spi_sck | output | 1 | Serial clock |
| spi_dout | output | 1 | Serial data to the device |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `STEP_CLKS` set to 3 and keeps the default operation codes. A step length above one makes the step-hold rule testable, because a counter that ends a step one clock early or late shows up against the reference model. Three is still short enough to run several complete requests, including back-to-back ones. With this setting the bench can also place a stray start strobe well inside a request, and can present a start strobe in the exact done cycle.

// File: rtl/spi_wr_pkg.sv
// Package: shared step encoding for the SPI register write sequencer.
// Assumes: consumers decode line levels from the phase value alone.
package spi_wr_pkg;

    typedef enum logic [3:0] {
        PH_IDLE     = 4'd0,
        PH_OPEN_LOW = 4'd1,
        PH_OPEN_CS  = 4'd2,
        PH_BIT_LO   = 4'd3,
        PH_BIT_HI   = 4'd4,
        PH_END_LOW  = 4'd5,
        PH_END_SK   = 4'd6,
        PH_CL_LOW   = 4'd7,
        PH_CL_SK    = 4'd8
    } phase_t;

endpackage

// File: rtl/spi_wr_step_timer.sv
// Module: step timer. Counts system clocks inside a step and raises
// tick on the last clock of each step.
// Assumes: run is high for the whole time a request is in progress.
module spi_wr_step_timer #(
    parameter int STEP_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    // Final clock of the current step.
    assign tick = run && (cnt == LAST);

    // Step clock counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/spi_wr_seq_fsm.sv
// Module: step sequencer. Walks through open, per-bit and close steps
// for the command transaction and then for the write transaction.
// Assumes: tick comes from the step timer and marks each step's end.
module spi_wr_seq_fsm
    import spi_wr_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int FRAME_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       tick,
    output phase_t                     phase,
    output logic                       txn,
    output logic [$clog2(FRAME_W)-1:0] bit_idx,
    output logic                       accept,
    output logic                       busy,
    output logic                       done
);
    localparam int IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_CMD   = IDX_W'(CMD_W - 1);
    localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAME_W - 1);

    logic [IDX_W-1:0] last_idx;

    // Index of the final bit of the transaction in progress.
    assign last_idx = txn ? LAST_FRAME : LAST_CMD;
    assign busy     = (phase != PH_IDLE);
    assign accept   = (phase == PH_IDLE) && start;

    // Phase, transaction and bit-index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            txn     <= 1'b0;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase   <= PH_OPEN_LOW;
                    txn     <= 1'b0;
                    bit_idx <= '0;
                end
            end else if (tick) begin
                case (phase)
                    PH_OPEN_LOW: phase <= PH_OPEN_CS;
                    PH_OPEN_CS:  phase <= PH_BIT_LO;
                    PH_BIT_LO:   phase <= PH_BIT_HI;
                    PH_BIT_HI: begin
                        if (bit_idx == last_idx) begin
                            bit_idx <= '0;
                            phase   <= PH_END_LOW;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            phase   <= PH_BIT_LO;
                        end
                    end
                    PH_END_LOW:  phase <= PH_END_SK;
                    PH_END_SK:   phase <= PH_CL_LOW;
                    PH_CL_LOW:   phase <= PH_CL_SK;
                    PH_CL_SK: begin
                        if (!txn) begin
                            txn   <= 1'b1;
                            phase <= PH_OPEN_LOW;
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    default:     phase <= PH_IDLE;
                endcase
            end
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= last_idx);

    p_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (phase == $past(phase)));

    p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> (phase == $past(phase)));

endmodule

// File: rtl/spi_wr_pins.sv
// Module: frame and line driver. Holds the captured address and data,
// builds the shifted word and decodes the line levels from the phase.
// Assumes: accept pulses only when a request is taken while idle.
module spi_wr_pins
    import spi_wr_pkg::*;
#(
    parameter int          OP_W    = 8,
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  WE_CODE = 8'h06,
    parameter logic [7:0]  WR_CODE = 8'h02
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        accept,
    input  logic [ADDR_W-1:0]                           addr_in,
    input  logic [DATA_W-1:0]                           data_in,
    input  phase_t                                      phase,
    input  logic                                        txn,
    input  logic [$clog2(OP_W+ADDR_W+DATA_W)-1:0]       bit_idx,
    output logic                                        cs,
    output logic                                        sck,
    output logic                                        dout
);
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int PAD_W   = FRAME_W - OP_W;

    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               rest_sk;
    logic [FRAME_W-1:0] word;
    logic [FRAME_W-1:0] shifted;
    logic               cur_bit;

    // Capture the request payload when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    // Idle clock level: high once any close sequence has run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest_sk <= 1'b0;
        end else if (phase == PH_CL_SK) begin
            rest_sk <= 1'b1;
        end
    end

    // Word for the current transaction, MSB aligned, and its current bit.
    always_comb begin
        if (txn) begin
            word = {WR_CODE[OP_W-1:0], addr_q, data_q};
        end else begin
            word = {WE_CODE[OP_W-1:0], {PAD_W{1'b0}}};
        end
        shifted = word << bit_idx;
        cur_bit = shifted[FRAME_W-1];
    end

    // Line levels for each step kind.
    always_comb begin
        cs   = 1'b0;
        sck  = 1'b0;
        dout = 1'b0;
        case (phase)
            PH_IDLE:    sck = rest_sk;
            PH_OPEN_CS: cs  = 1'b1;
            PH_BIT_LO: begin
                cs   = 1'b1;
                dout = cur_bit;
            end
            PH_BIT_HI: begin
                cs   = 1'b1;
                sck  = 1'b1;
                dout = cur_bit;
            end
            PH_END_SK:  sck = 1'b1;
            PH_CL_SK:   sck = 1'b1;
            default: begin
                cs   = 1'b0;
                sck  = 1'b0;
                dout = 1'b0;
            end
        endcase
    end

    p_payload_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(addr_q) && $stable(data_q)));

    p_rest_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rest_sk |=> rest_sk);

endmodule

// File: rtl/spi_regwr_seq.sv
// Module: SPI register write sequencer top. One start strobe produces a
// write-enable command transaction, then an operation/address/data
// transaction, each closed by a fixed close sequence.
// Assumes: start is synchronous to clk; the device samples on rising sck.
module spi_regwr_seq
    import spi_wr_pkg::*;
#(
    parameter int          STEP_CLKS = 4,
    parameter int          OP_W      = 8,
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  WE_CODE   = 8'h06,
    parameter logic [7:0]  WR_CODE   = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_data,
    output logic              spi_cs,
    output logic              spi_sck,
    output logic              spi_dout,
    output logic              done
);
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    phase_t           phase;
    logic             txn;
    logic [IDX_W-1:0] bit_idx;
    logic             accept;
    logic             busy;
    logic             tick;

    spi_wr_step_timer #(
        .STEP_CLKS (STEP_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spi_wr_seq_fsm #(
        .CMD_W   (OP_W),
        .FRAME_W (FRAME_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .phase   (phase),
        .txn     (txn),
        .bit_idx (bit_idx),
        .accept  (accept),
        .busy    (busy),
        .done    (done)
    );

    spi_wr_pins #(
        .OP_W    (OP_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WE_CODE (WE_CODE),
        .WR_CODE (WR_CODE)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .addr_in (reg_addr),
        .data_in (reg_data),
        .phase   (phase),
        .txn     (txn),
        .bit_idx (bit_idx),
        .cs      (spi_cs),
        .sck     (spi_sck),
        .dout    (spi_dout)
    );

    p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_cs);

    p_sck_rise_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_sck) && spi_cs) |-> $stable(spi_dout));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!spi_cs && spi_sck && !spi_dout));

endmodule

// File: tb/spi_regwr_seq_test.sv
module spi_regwr_seq_test;
    localparam int         STEP = 3;
    localparam logic [7:0] WE   = 8'h06;
    localparam logic [7:0] WR   = 8'h02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] data = 8'h00;
    logic       cs, sk, di, done;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_regwr_seq #(
        .STEP_CLKS (STEP),
        .WE_CODE   (WE),
        .WR_CODE   (WR)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .reg_addr (addr),
        .reg_data (data),
        .spi_cs   (cs),
        .spi_sck  (sk),
        .spi_dout (di),
        .done     (done)
    );

    // Reference model: queue of expected {cs,sk,di,done} per clock.
    logic [3:0]  q_pins[$];
    string       q_tag[$];
    logic [23:0] q_word[$];
    int          q_len[$];
    logic [3:0]  exp_pins = 4'b0000;
    string       exp_tag = "R7";
    logic        rest_sk = 1'b0;
    bit          model_on = 1'b0;

    task automatic push_step(input logic c, input logic s, input logic d, input string t);
        repeat (STEP) begin
            q_pins.push_back({c, s, d, 1'b0});
            q_tag.push_back(t);
        end
    endtask

    task automatic push_txn(input logic [23:0] w, input int n);
        push_step(1'b0, 1'b0, 1'b0, "R3");
        push_step(1'b1, 1'b0, 1'b0, "R3");
        for (int i = 0; i < n; i++) begin
            push_step(1'b1, 1'b0, w[23-i], "R4");
            push_step(1'b1, 1'b1, w[23-i], "R4");
        end
        push_step(1'b0, 1'b0, 1'b0, "R5");
        push_step(1'b0, 1'b1, 1'b0, "R5");
        push_step(1'b0, 1'b0, 1'b0, "R5");
        push_step(1'b0, 1'b1, 1'b0, "R5");
    endtask

    always @(posedge clk) begin
        model_on = 1'b1;
        if (!rst_n) begin
            q_pins.delete();
            q_tag.delete();
            exp_pins = 4'b0000;
            exp_tag  = "R7";
            rest_sk  = 1'b0;
        end else begin
            if (q_pins.size() == 0 && start) begin
                push_txn({WE, 16'h0000}, 8);
                push_txn({WR, addr, data}, 24);
                q_pins.push_back(4'b0101);
                q_tag.push_back("R7");
                q_word.push_back({16'h0000, WE});
                q_len.push_back(8);
                q_word.push_back({WR, addr, data});
                q_len.push_back(24);
            end
            if (q_pins.size() > 0) begin
                exp_pins = q_pins.pop_front();
                exp_tag  = q_tag.pop_front();
                if (exp_pins[0]) rest_sk = 1'b1;
            end else begin
                exp_pins = {1'b0, rest_sk, 2'b00};
                exp_tag  = "R7";
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R6 via step lengths).
    always @(negedge clk) begin
        if (model_on && !finished) begin
            check({cs, sk, di, done} === exp_pins, exp_tag, "lines {cs,sk,di,done}",
                  {28'h0, cs, sk, di, done}, {28'h0, exp_pins});
            if (done) done_cnt++;
        end
    end

    // Independent serial decode: sample data on each rising clock with cs high.
    logic [23:0] shreg = '0;
    int          nbits = 0;
    logic        prev_sk = 1'b0;
    logic        prev_cs = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            nbits = 0;
        end else begin
            if (cs && sk && !prev_sk) begin
                shreg = {shreg[22:0], di};
                nbits++;
            end
            if (prev_cs && !cs) begin
                if (q_word.size() > 0) begin
                    logic [23:0] ew;
                    int          el;
                    logic [23:0] mask;
                    ew = q_word.pop_front();
                    el = q_len.pop_front();
                    mask = (el == 24) ? 24'hFFFFFF : 24'h0000FF;
                    check(nbits == el, "R2", "bit count", nbits, el);
                    check((shreg & mask) == ew, "R2", "decoded word",
                          {8'h0, shreg & mask}, {8'h0, ew});
                end else begin
                    check(1'b0, "R2", "unexpected transaction", nbits, 0);
                end
                nbits = 0;
            end
        end
        prev_sk = sk;
        prev_cs = cs;
    end

    task automatic issue(input logic [7:0] a, input logic [7:0] d);
        addr  = a;
        data  = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        writes++;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, "R7", "done within limit", {31'h0, done}, 1);
    endtask

    task automatic check_rest();
        @(negedge clk);
        check({cs, sk, di, done} === 4'b0100, "R7", "rest levels after done",
              {28'h0, cs, sk, di, done}, 32'h4);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        check({cs, sk, di, done} === 4'b0000, "R7", "reset levels",
              {28'h0, cs, sk, di, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs, sk, di, done} === 4'b0000, "R7", "idle before first write",
              {28'h0, cs, sk, di, done}, 0);

        // R1: a stray start mid-request must not change the sent bytes.
        issue(8'h3C, 8'hA5);
        repeat (40) @(negedge clk);
        addr  = 8'hFF;
        data  = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_rest();

        // Extreme patterns, then R8: start presented in the done cycle.
        repeat (5) @(negedge clk);
        issue(8'h00, 8'hFF);
        wait_done();
        issue(8'h81, 8'h7E);
        wait_done();
        check_rest();

        issue(8'hFF, 8'h00);
        wait_done();
        check_rest();
        repeat (3) @(negedge clk);

        check(done_cnt == writes, "R1", "done pulses per accepted start",
              done_cnt, writes);
        check(q_word.size() == 0, "R2", "all transactions seen",
              q_word.size(), 0);
        summary();
    end
endmodule